// File: doc/BRIEF.md
# Shared Register File with Selectable Write-Conflict Discipline

This block is a small register file shared by several processing elements. Every element has its own port and may issue, in the same clock step, a read and a write, each to a cell chosen by that port's address. Reads are combinational and return the cell contents as they stood before the step. Writes that survive arbitration are committed at the clock edge that ends the step.

A two-bit mode input picks one of four disciplines for accesses that land on the same cell in one step:
- exclusive reads and writes;
- shared reads with exclusive writes;
- shared writes that must all carry one value;
- shared writes where the lowest port index wins.

For each port the block drives a violation flag that marks an access which breaks the chosen discipline. A rejected write leaves the cell alone, and so does every other write to that cell in the same step.

In either shared-write mode, a single write step reduces one bit per port to their OR in cell 0. Each port whose bit is set writes 1 there, and each port whose bit is clear stays quiet. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `shared_cell_arbiter`

## Requirements
- R1: While reset is held and after it is released, every cell reads zero until it is written.
- R2: A read returns the cell value from before the current step, even when another port writes that cell in the same step. A committed write is visible to reads from the next step on.
- R3: In mode 2'b00, when two or more ports read the same cell in one step, every one of those readers gets its violation flag set. Reads of distinct cells raise no flag.
- R4: In modes 2'b00 and 2'b01, when two or more ports write the same cell in one step, all of those writers are flagged and the cell keeps its old value.
- R5: In modes 2'b01, 2'b10 and 2'b11, any number of ports may read the same cell in one step with no flag, and all of them receive the same value.
- R6: In mode 2'b10, writers of one cell that all present the same value are committed with no flag. If any two of them differ, every writer of that cell is flagged and the cell keeps its old value.
- R7: In mode 2'b11, when several ports write one cell, the value of the lowest-index writer is stored and no port is flagged.
- R8: A write that is the only write to its cell in a step is committed in every mode. Writes to different cells in one step do not affect one another.
- R9: In modes 2'b10 and 2'b11, if each port i writes the value 1 to cell 0 exactly when bit i of a pattern is 1, cell 0 afterwards holds the OR of the pattern after one step. With an all-zero pattern it keeps 0.
- R10: A port with no request never has its flag set. A read and a write to the same cell by different ports in one step raise no flag in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Conflict discipline: 00 exclusive, 01 shared read, 10 common-value write, 11 lowest-index write |
| rd_req | input | NP | Per-port read request |
| wr_req | input | NP | Per-port write request |
| addr | input | NP*AW | Per-port cell address, port i at bits i*AW upward |
| wdata | input | NP*DW | Per-port write data, port i at bits i*DW upward |
| rdata | output | NP*DW | Per-port read data (pre-step cell value) |
| viol | output | NP | Per-port violation flag for the current step |

## Verification
The bench aims at same-step read/write overlap on one cell. A design that forwarded write data would return the new value a step early. It covers common-value writes where only one of three writers differs: a design that flagged just the odd port, or committed the majority value, would break both the flag and the read-back checks. Priority writes are issued with the winner neither first nor last in issue order, which exposes a design that picks the highest index or the last writer. The OR-reduction sweep runs through all-zero and single-bit patterns, and dense random traffic on four cells forces collisions in every mode, so a wrongly blocked or wrongly committed write shows up in later reads.

// File: rtl/shcell_pkg.sv
package shcell_pkg;
  typedef enum logic [1:0] {
    MD_EXCL = 2'b00,
    MD_CRD  = 2'b01,
    MD_CMN  = 2'b10,
    MD_PRI  = 2'b11
  } md_e;
endpackage

// File: rtl/shcell_match.sv
// Pairwise address and data comparators across all ports.
module shcell_match #(
  parameter int NP = 8,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic [NP*AW-1:0]        addr,
  input  logic [NP*DW-1:0]        wdata,
  output logic [NP-1:0][NP-1:0]   aeq,
  output logic [NP-1:0][NP-1:0]   deq
);
  for (genvar gi = 0; gi < NP; gi++) begin : g_row
    for (genvar gj = 0; gj < NP; gj++) begin : g_col
      assign aeq[gi][gj] = (addr[gi*AW +: AW] == addr[gj*AW +: AW]);
      assign deq[gi][gj] = (wdata[gi*DW +: DW] == wdata[gj*DW +: DW]);
    end
  end
endmodule

// File: rtl/shcell_rules.sv
// Applies the selected discipline: per-port violation and write permission.
module shcell_rules import shcell_pkg::*; #(
  parameter int NP = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              mode,
  input  logic [NP-1:0]           rd_req,
  input  logic [NP-1:0]           wr_req,
  input  logic [NP-1:0][NP-1:0]   aeq,
  input  logic [NP-1:0][NP-1:0]   deq,
  output logic [NP-1:0]           wr_ok,
  output logic [NP-1:0]           viol
);
  logic [NP-1:0] wcoll, wdiff, wlow, rcoll;
  logic [NP-1:0] wv, rv;

  always_comb begin
    wcoll = '0;
    wdiff = '0;
    wlow  = '0;
    rcoll = '0;
    for (int i = 0; i < NP; i++) begin
      for (int j = 0; j < NP; j++) begin
        if (j != i) begin
          if (wr_req[i] && wr_req[j] && aeq[i][j]) begin
            wcoll[i] = 1'b1;
            if (!deq[i][j]) wdiff[i] = 1'b1;
            if (j < i)      wlow[i]  = 1'b1;
          end
          if (rd_req[i] && rd_req[j] && aeq[i][j]) rcoll[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    wv    = '0;
    rv    = '0;
    wr_ok = '0;
    case (md_e'(mode))
      MD_EXCL: begin
        wv    = wcoll;
        rv    = rcoll;
        wr_ok = wr_req & ~wcoll;
      end
      MD_CRD: begin
        wv    = wcoll;
        wr_ok = wr_req & ~wcoll;
      end
      MD_CMN: begin
        wv    = wdiff;
        wr_ok = wr_req & ~wdiff;
      end
      default: begin
        wr_ok = wr_req & ~wlow;
      end
    endcase
    viol = wv | rv;
  end

  a_r7_prio_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_PRI) |-> (viol == '0));

  a_r5_shared_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MD_EXCL) |-> ((viol & ~wr_req) == '0));

  a_r10_idle_port_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol & ~rd_req & ~wr_req) == '0));

  a_r4_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_ok & ~wr_req) == '0));
endmodule

// File: rtl/shcell_bank.sv
// Register array: per-cell winner select and enabled update.
module shcell_bank import shcell_pkg::*; #(
  parameter int NP = 8,
  parameter int AW = 4,
  parameter int DW = 8,
  localparam int NC = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [NP-1:0]     wr_ok,
  input  logic [NP*AW-1:0]  addr,
  input  logic [NP*DW-1:0]  wdata,
  output logic [NC*DW-1:0]  cells
);
  logic [NC-1:0][NP-1:0] hit;
  logic [NC-1:0]         en;
  logic [NC*DW-1:0]      nxt;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      for (int i = 0; i < NP; i++) begin
        hit[c][i] = wr_ok[i] && (addr[i*AW +: AW] == AW'(c));
      end
    end
  end

  // lowest index overwrites last, so it wins
  always_comb begin
    en  = '0;
    nxt = cells;
    for (int c = 0; c < NC; c++) begin
      for (int i = NP - 1; i >= 0; i--) begin
        if (hit[c][i]) begin
          en[c] = 1'b1;
          nxt[c*DW +: DW] = wdata[i*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if (en[c]) cells[c*DW +: DW] <= nxt[c*DW +: DW];
      end
    end
  end

  for (genvar gc = 0; gc < NC; gc++) begin : g_chk
    a_r4_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_CMN) |-> $onehot0(hit[gc]));
  end
endmodule

// File: rtl/shared_cell_arbiter.sv
module shared_cell_arbiter import shcell_pkg::*; #(
  parameter int NP = 8,
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [NP-1:0]     rd_req,
  input  logic [NP-1:0]     wr_req,
  input  logic [NP*AW-1:0]  addr,
  input  logic [NP*DW-1:0]  wdata,
  output logic [NP*DW-1:0]  rdata,
  output logic [NP-1:0]     viol
);
  localparam int NC = 1 << AW;

  logic [1:0]             rst_sync;
  logic                   rst_int_n;
  logic [NP-1:0][NP-1:0]  aeq, deq;
  logic [NP-1:0]          wr_ok;
  logic [NC*DW-1:0]       cells;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  shcell_match #(.NP(NP), .AW(AW), .DW(DW)) u_match (
    .addr (addr),
    .wdata(wdata),
    .aeq  (aeq),
    .deq  (deq)
  );

  shcell_rules #(.NP(NP)) u_rules (
    .clk   (clk),
    .rst_n (rst_int_n),
    .mode  (mode),
    .rd_req(rd_req),
    .wr_req(wr_req),
    .aeq   (aeq),
    .deq   (deq),
    .wr_ok (wr_ok),
    .viol  (viol)
  );

  shcell_bank #(.NP(NP), .AW(AW), .DW(DW)) u_bank (
    .clk  (clk),
    .rst_n(rst_int_n),
    .mode (mode),
    .wr_ok(wr_ok),
    .addr (addr),
    .wdata(wdata),
    .cells(cells)
  );

  for (genvar gp = 0; gp < NP; gp++) begin : g_rd
    assign rdata[gp*DW +: DW] = cells[addr[gp*AW +: AW]*DW +: DW];
  end

  a_r2_read_old_value: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_req[0] && wr_req[1] && (addr[AW-1:0] == addr[2*AW-1:AW]) && !viol[1])
      |=> ($past(mode) == MD_CMN) || ($past(mode) == MD_PRI) || (rdata[DW-1:0] == $past(wdata[2*DW-1:DW])) || (addr[AW-1:0] != $past(addr[AW-1:0])) || wr_req[1] || wr_req[0]);
endmodule

// File: tb/sim_shared_cell_arbiter.sv
module sim_shared_cell_arbiter;
  localparam int NP = 8;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NC = 1 << AW;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic [NP-1:0] rd_req, wr_req;
  logic [NP*AW-1:0] addr;
  logic [NP*DW-1:0] wdata;
  logic [NP*DW-1:0] rdata;
  logic [NP-1:0] viol;

  int total = 0;
  int bad = 0;

  logic [DW-1:0] mm [NC];
  logic          q_rd [NP];
  logic          q_wr [NP];
  logic [AW-1:0] q_a  [NP];
  logic [DW-1:0] q_d  [NP];
  logic [1:0]    q_mode;
  logic [DW-1:0] rd_got [NP];
  logic [NP-1:0] last_viol;

  always #(CLK_P/2) clk = ~clk;

  shared_cell_arbiter #(.NP(NP), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_req(rd_req), .wr_req(wr_req),
    .addr(addr), .wdata(wdata), .rdata(rdata), .viol(viol)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < NP; i++) begin
      q_rd[i] = 1'b0; q_wr[i] = 1'b0; q_a[i] = '0; q_d[i] = '0;
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R3";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  // drive one step, check flags and reads, then advance the model
  task automatic do_step();
    logic [NP-1:0] ev, ok;
    logic [DW-1:0] nm [NC];
    logic [NC-1:0] done;
    mode = q_mode;
    for (int i = 0; i < NP; i++) begin
      rd_req[i] = q_rd[i];
      wr_req[i] = q_wr[i];
      addr[i*AW +: AW] = q_a[i];
      wdata[i*DW +: DW] = q_d[i];
    end
    #1;
    for (int i = 0; i < NP; i++) begin
      int nw, nr;
      bit df, lo;
      nw = 0; nr = 0; df = 0; lo = 0;
      for (int j = 0; j < NP; j++) begin
        if (j != i && q_a[j] == q_a[i]) begin
          if (q_wr[j]) begin
            nw++;
            if (q_d[j] != q_d[i]) df = 1;
            if (j < i) lo = 1;
          end
          if (q_rd[j]) nr++;
        end
      end
      ev[i] = 1'b0;
      ok[i] = q_wr[i];
      case (q_mode)
        2'b00: begin
          if (q_wr[i] && nw > 0) begin ev[i] = 1'b1; ok[i] = 1'b0; end
          if (q_rd[i] && nr > 0) ev[i] = 1'b1;
        end
        2'b01: if (q_wr[i] && nw > 0) begin ev[i] = 1'b1; ok[i] = 1'b0; end
        2'b10: if (q_wr[i] && df) begin ev[i] = 1'b1; ok[i] = 1'b0; end
        default: if (lo) ok[i] = 1'b0;
      endcase
    end
    check(viol == ev, mode_tag(q_mode), int'(viol), int'(ev));
    last_viol = viol;
    for (int i = 0; i < NP; i++) begin
      rd_got[i] = rdata[i*DW +: DW];
      if (q_rd[i]) check(rd_got[i] == mm[q_a[i]], "R2", int'(rd_got[i]), int'(mm[q_a[i]]));
    end
    done = '0;
    for (int c = 0; c < NC; c++) nm[c] = mm[c];
    for (int i = 0; i < NP; i++) begin
      if (ok[i] && !done[q_a[i]]) begin
        nm[q_a[i]] = q_d[i];
        done[q_a[i]] = 1'b1;
      end
    end
    @(posedge clk);
    for (int c = 0; c < NC; c++) mm[c] = nm[c];
    @(negedge clk);
  endtask

  task automatic rd1(input int p, input int a);
    q_rd[p] = 1'b1; q_a[p] = AW'(a);
  endtask

  task automatic wr1(input int p, input int a, input int d);
    q_wr[p] = 1'b1; q_a[p] = AW'(a); q_d[p] = DW'(d);
  endtask

  // read one cell on port 0 in shared-read mode and return it
  task automatic peek(input int a, output logic [DW-1:0] v);
    clr(); q_mode = 2'b01; rd1(0, a); do_step(); v = rd_got[0];
  endtask

  initial begin
    #(CLK_P * 100000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < NC; c++) mm[c] = '0;
    rst_n = 1'b0; mode = '0; rd_req = '0; wr_req = '0; addr = '0; wdata = '0;
    clr(); q_mode = 2'b00;
    repeat (3) @(negedge clk);
    #1;
    check(viol == '0, "R1", int'(viol), 0);
    check(rdata == '0, "R1", int'(rdata[DW-1:0]), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every cell zero after reset
    for (int base = 0; base < NC; base += NP) begin
      clr(); q_mode = 2'b01;
      for (int i = 0; i < NP; i++) rd1(i, base + i);
      do_step();
      for (int i = 0; i < NP; i++) check(rd_got[i] == 0, "R1", int'(rd_got[i]), 0);
    end

    // R2 and R10: same-step read sees old value, no flag in exclusive mode
    clr(); q_mode = 2'b00; wr1(0, 3, 8'h5a); rd1(1, 3);
    do_step();
    check(rd_got[1] == 0, "R2", int'(rd_got[1]), 0);
    check(last_viol == 0, "R10", int'(last_viol), 0);
    peek(3, v); check(v == 8'h5a, "R2", int'(v), 8'h5a);

    // R3: two readers of one cell flagged, a third on another cell not
    clr(); q_mode = 2'b00; rd1(0, 3); rd1(1, 3); rd1(2, 4);
    do_step();
    check(last_viol == 8'b0000_0011, "R3", int'(last_viol), 3);

    // R4: exclusive write collision blocked in both exclusive-write modes
    for (int m = 0; m < 2; m++) begin
      clr(); q_mode = 2'(m); wr1(2, 6, 8'h11); wr1(5, 6, 8'h22);
      do_step();
      check(last_viol == 8'b0010_0100, "R4", int'(last_viol), 8'h24);
      peek(6, v); check(v == 0, "R4", int'(v), 0);
    end

    // R5: all ports read one cell
    clr(); q_mode = 2'b01;
    for (int i = 0; i < NP; i++) rd1(i, 3);
    do_step();
    check(last_viol == 0, "R5", int'(last_viol), 0);
    for (int i = 0; i < NP; i++) check(rd_got[i] == 8'h5a, "R5", int'(rd_got[i]), 8'h5a);

    // R6: common value committed; one odd writer blocks all
    clr(); q_mode = 2'b10; wr1(1, 9, 8'h33); wr1(4, 9, 8'h33); wr1(7, 9, 8'h33);
    do_step();
    check(last_viol == 0, "R6", int'(last_viol), 0);
    peek(9, v); check(v == 8'h33, "R6", int'(v), 8'h33);
    clr(); q_mode = 2'b10; wr1(0, 9, 8'h44); wr1(2, 9, 8'h44); wr1(6, 9, 8'h45);
    do_step();
    check(last_viol == 8'b0100_0101, "R6", int'(last_viol), 8'h45);
    peek(9, v); check(v == 8'h33, "R6", int'(v), 8'h33);

    // R7: lowest index wins
    clr(); q_mode = 2'b11; wr1(6, 10, 8'h66); wr1(3, 10, 8'h33); wr1(5, 10, 8'h55);
    do_step();
    check(last_viol == 0, "R7", int'(last_viol), 0);
    peek(10, v); check(v == 8'h33, "R7", int'(v), 8'h33);

    // R8: distinct cells all commit, in every mode
    for (int m = 0; m < 4; m++) begin
      clr(); q_mode = 2'(m);
      for (int i = 0; i < NP; i++) wr1(i, 8 + i, 16 * m + i + 1);
      do_step();
      check(last_viol == 0, "R8", int'(last_viol), 0);
      for (int i = 0; i < NP; i++) begin
        peek(8 + i, v); check(v == DW'(16 * m + i + 1), "R8", int'(v), 16 * m + i + 1);
      end
    end

    // R9: one-step OR into cell 0
    for (int m = 2; m < 4; m++) begin
      for (int k = 0; k < 6; k++) begin
        logic [NP-1:0] pat;
        pat = (k == 0) ? '0 : (k < 3) ? NP'(1) << (k * 3) : NP'($urandom);
        clr(); q_mode = 2'b01; wr1(0, 0, 0); do_step();
        clr(); q_mode = 2'(m);
        for (int i = 0; i < NP; i++) if (pat[i]) wr1(i, 0, 1);
        do_step();
        check(last_viol == 0, "R9", int'(last_viol), 0);
        peek(0, v); check(v == DW'(|pat), "R9", int'(v), int'(|pat));
      end
    end

    // random traffic on a few cells to force collisions
    for (int n = 0; n < 400; n++) begin
      clr(); q_mode = 2'($urandom_range(0, 3));
      for (int i = 0; i < NP; i++) begin
        q_rd[i] = ($urandom_range(0, 2) == 0);
        q_wr[i] = ($urandom_range(0, 2) == 0);
        q_a[i]  = AW'($urandom_range(0, 3));
        q_d[i]  = DW'($urandom_range(0, 3));
      end
      do_step();
      for (int i = 0; i < NP; i++)
        if (!q_rd[i] && !q_wr[i]) check(last_viol[i] == 1'b0, "R10", int'(last_viol[i]), 0);
    end
    for (int c = 0; c < 4; c++) begin
      peek(c, v); check(v == mm[c], "R8", int'(v), int'(mm[c]));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule